// File: doc/BRIEF.md
# Maskable Interrupt Arbiter with Global Enable

This block decides when a processor core takes a maskable interrupt and which source it takes. Each of up to fifteen sources has a pending flag, which its event sets, and an enable bit that software owns. A single global enable gates all of them. The block checks for a request once per instruction, on the instruction-start strobe from the sequencer. It raises a one-cycle request that carries the index of the highest-ranked qualifying source. Fetching the vector and saving context stay with the sequencer.

Event inputs may be asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector before it sets its pending flag. Software writes whole-register images of the pending and enable bits and writes the global enable. The sequencer pulses the global enable on and off around service entry and return. A combinational view always shows the highest active source, whatever the global enable holds, so a service routine can look up which handler to dispatch to.

The request logic is a two-state machine. In `ST_IDLE` no request is driven. The transition `qualify` (instruction start with a qualifying source) moves it to `ST_FIRE`, where `req_o` is high for exactly one cycle. From `ST_FIRE` it takes `qualify` again to stay in `ST_FIRE` with a fresh index, or `settle` back to `ST_IDLE`.

Top module: `irq_mask_arb`

## Requirements
- R1: A rising edge on `evt_i[k]` sets `pend_o[k]` no later than the third rising clock edge after the edge that first samples the new level. This happens whatever the enable bits and global enable hold.
- R2: Source k is active when `pend_o[k]` and `en_o[k]` are both 1. `act_valid_o` is 1 exactly when some source is active. `act_idx_o` gives the highest active index, or 0 when none is active.
- R3: `req_o` is 1 in the cycle after a clock edge that samples `instr_start_i`=1 with at least one active source, `gie_o`=1 and `nmi_busy_i`=0. In every other cycle it is 0.
- R4: When several sources are active, `req_idx_o` is the highest index (index 14 ranks above index 0), and the pending bits of all the others remain 1.
- R5: Reset clears every pending bit, every enable bit, the global enable and the request output.
- R6: A pending bit that is already 1 before software sets its enable bit produces a request at the first instruction start after the enable write, provided the global enable is 1.
- R7: Raising a request clears no pending bit. Only a pending write (`pend_wr_i`, which loads `pend_wdata_i` into all bits) clears one.
- R8: When an edge-detected event and a pending write of 0 for the same bit land on the same clock edge, the bit ends up 1.
- R9: The global enable is cleared by `gie_clr_i`, set by `gie_set_i` when there is no clear, and loaded from `gie_wdata_i` by `gie_wr_i` when neither pulse is present. The clear ranks above everything else.
- R10: An event input that stays high sets its pending bit only once. After software clears that bit, it stays 0 for as long as the input is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | Asynchronous event inputs, one per source |
| pend_wr_i | input | 1 | Load the pending register from pend_wdata_i |
| pend_wdata_i | input | NSRC | Pending register write image |
| en_wr_i | input | 1 | Load the enable register from en_wdata_i |
| en_wdata_i | input | NSRC | Enable register write image |
| gie_wr_i | input | 1 | Software write of the global enable |
| gie_wdata_i | input | 1 | Value for the global enable write |
| gie_set_i | input | 1 | Sequencer pulse that sets the global enable |
| gie_clr_i | input | 1 | Sequencer pulse that clears the global enable |
| instr_start_i | input | 1 | Instruction boundary strobe |
| nmi_busy_i | input | 1 | A non-maskable service is in progress |
| req_o | output | 1 | One-cycle interrupt request |
| req_idx_o | output | IDXW | Index of the requesting source, valid with req_o |
| act_valid_o | output | 1 | Some source is active |
| act_idx_o | output | IDXW | Highest active source index |
| pend_o | output | NSRC | Pending bits |
| en_o | output | NSRC | Enable bits |
| gie_o | output | 1 | Global enable |

## Verification
The bench sweeps every pair of pending sources and every single enable mask. A priority encoder that ranked low indices first, or that dropped the losing sources, would report the wrong index or would show losing bits cleared. It lands an event edge on the same clock edge as a clearing write, which a design that put the write last would lose. It also holds an event high after a clear, which a level-sensitive design would reassert at once. It checks that a request is held back by a clear global enable, by non-maskable service and by a missing instruction strobe. It then shows that an enable written after the pending bit fires at the next strobe. Finally it drives the global-enable pulses in combination with each other, which catches a design that gives set or write priority over clear.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } req_st_e;

endpackage

// File: rtl/irq_evt_sync.sv
module irq_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic rise_o
);

    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= evt_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~last_q;

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs #(
    parameter int NSRC = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] rise_i,
    input  logic            pend_wr_i,
    input  logic [NSRC-1:0] pend_wdata_i,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic            gie_wr_i,
    input  logic            gie_wdata_i,
    input  logic            gie_set_i,
    input  logic            gie_clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] en_o,
    output logic            gie_o
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] en_q;
    logic            gie_q;
    logic [NSRC-1:0] pend_base;
    logic            gie_nxt;

    // Software image first, then event edges OR-ed on top so they always win.
    always_comb begin
        pend_base = pend_wr_i ? pend_wdata_i : pend_q;
    end

    always_comb begin
        if (gie_clr_i) begin
            gie_nxt = 1'b0;
        end else if (gie_set_i) begin
            gie_nxt = 1'b1;
        end else if (gie_wr_i) begin
            gie_nxt = gie_wdata_i;
        end else begin
            gie_nxt = gie_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            gie_q  <= 1'b0;
        end else begin
            pend_q <= pend_base | rise_i;
            if (en_wr_i) begin
                en_q <= en_wdata_i;
            end
            gie_q <= gie_nxt;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign gie_o  = gie_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NSRC = 15,
    parameter int IDXW = 4
) (
    input  logic [NSRC-1:0] act_i,
    output logic            valid_o,
    output logic [IDXW-1:0] idx_o
);

    // Scan upward; the last hit is the highest index and therefore the winner.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (act_i[k]) begin
                valid_o = 1'b1;
                idx_o   = IDXW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_arb_pkg::*;
#(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_start_i,
    input  logic            gie_i,
    input  logic            nmi_busy_i,
    input  logic            win_valid_i,
    input  logic [IDXW-1:0] win_idx_i,
    output logic            req_o,
    output logic [IDXW-1:0] req_idx_o
);

    req_st_e         state_q;
    req_st_e         state_d;
    logic            qualify;
    logic [IDXW-1:0] idx_q;

    assign qualify = instr_start_i & gie_i & ~nmi_busy_i & win_valid_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = qualify ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = qualify ? ST_FIRE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (qualify) begin
            idx_q <= win_idx_i;
        end
    end

    always_comb begin
        req_o     = 1'b0;
        req_idx_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_o     = 1'b0;
                req_idx_o = '0;
            end
            ST_FIRE: begin
                req_o     = 1'b1;
                req_idx_o = idx_q;
            end
            default: begin
                req_o     = 1'b0;
                req_idx_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_mask_arb.sv
module irq_mask_arb #(
    parameter int NSRC = 15,
    parameter int IDXW = $clog2(NSRC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            pend_wr_i,
    input  logic [NSRC-1:0] pend_wdata_i,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic            gie_wr_i,
    input  logic            gie_wdata_i,
    input  logic            gie_set_i,
    input  logic            gie_clr_i,
    input  logic            instr_start_i,
    input  logic            nmi_busy_i,
    output logic            req_o,
    output logic [IDXW-1:0] req_idx_o,
    output logic            act_valid_o,
    output logic [IDXW-1:0] act_idx_o,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] en_o,
    output logic            gie_o
);

    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] active;

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        irq_evt_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[g]),
            .rise_o (rise[g])
        );
    end

    irq_flag_regs #(.NSRC(NSRC)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (rise),
        .pend_wr_i    (pend_wr_i),
        .pend_wdata_i (pend_wdata_i),
        .en_wr_i      (en_wr_i),
        .en_wdata_i   (en_wdata_i),
        .gie_wr_i     (gie_wr_i),
        .gie_wdata_i  (gie_wdata_i),
        .gie_set_i    (gie_set_i),
        .gie_clr_i    (gie_clr_i),
        .pend_o       (pend_o),
        .en_o         (en_o),
        .gie_o        (gie_o)
    );

    assign active = pend_o & en_o;

    irq_prio_enc #(.NSRC(NSRC), .IDXW(IDXW)) u_enc (
        .act_i   (active),
        .valid_o (act_valid_o),
        .idx_o   (act_idx_o)
    );

    irq_req_fsm #(.IDXW(IDXW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_start_i (instr_start_i),
        .gie_i         (gie_o),
        .nmi_busy_i    (nmi_busy_i),
        .win_valid_i   (act_valid_o),
        .win_idx_i     (act_idx_o),
        .req_o         (req_o),
        .req_idx_o     (req_idx_o)
    );

endmodule

// File: rtl/irq_mask_arb_chk.sv
module irq_mask_arb_chk #(
    parameter int NSRC = 15,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pend_wr_i,
    input logic            gie_wr_i,
    input logic            gie_set_i,
    input logic            gie_clr_i,
    input logic            instr_start_i,
    input logic            nmi_busy_i,
    input logic            req_o,
    input logic [IDXW-1:0] req_idx_o,
    input logic            act_valid_o,
    input logic [IDXW-1:0] act_idx_o,
    input logic [NSRC-1:0] pend_o,
    input logic [NSRC-1:0] en_o,
    input logic            gie_o
);

    // R3: a request needs a strobe, global enable and no non-maskable service one cycle earlier
    a_r3_req_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(instr_start_i && gie_o && !nmi_busy_i && ((pend_o & en_o) != '0)));

    // R4: the reported index is active and nothing above it was active
    a_r4_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ((32'($past(pend_o & en_o)) >> req_idx_o) == 32'd1));

    // R5: reset leaves every flag and the request at zero
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pend_o == '0 && en_o == '0 && !gie_o && !req_o));

    // R7: without a pending write, no set pending bit drops
    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R2: the active index reads zero when nothing is active
    a_r2_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid_o |-> (act_idx_o == '0));

    // R9: a clear pulse always leaves the global enable at zero
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_i |=> !gie_o);

    // R9: with no pulse and no write the global enable holds
    a_r9_gie_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_clr_i && !gie_set_i && !gie_wr_i) |=> $stable(gie_o));

endmodule

bind irq_mask_arb irq_mask_arb_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend_wr_i     (pend_wr_i),
    .gie_wr_i      (gie_wr_i),
    .gie_set_i     (gie_set_i),
    .gie_clr_i     (gie_clr_i),
    .instr_start_i (instr_start_i),
    .nmi_busy_i    (nmi_busy_i),
    .req_o         (req_o),
    .req_idx_o     (req_idx_o),
    .act_valid_o   (act_valid_o),
    .act_idx_o     (act_idx_o),
    .pend_o        (pend_o),
    .en_o          (en_o),
    .gie_o         (gie_o)
);

// File: tb/tb_irq_mask_arb.sv
`timescale 1ns/1ps
module tb_irq_mask_arb;

    localparam int NSRC = 15;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic            pend_wr_i = 1'b0;
    logic [NSRC-1:0] pend_wdata_i = '0;
    logic            en_wr_i = 1'b0;
    logic [NSRC-1:0] en_wdata_i = '0;
    logic            gie_wr_i = 1'b0;
    logic            gie_wdata_i = 1'b0;
    logic            gie_set_i = 1'b0;
    logic            gie_clr_i = 1'b0;
    logic            instr_start_i = 1'b0;
    logic            nmi_busy_i = 1'b0;
    logic            req_o;
    logic [IDXW-1:0] req_idx_o;
    logic            act_valid_o;
    logic [IDXW-1:0] act_idx_o;
    logic [NSRC-1:0] pend_o;
    logic [NSRC-1:0] en_o;
    logic            gie_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_mask_arb #(.NSRC(NSRC), .IDXW(IDXW)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .pend_wr_i(pend_wr_i), .pend_wdata_i(pend_wdata_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i),
        .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
        .instr_start_i(instr_start_i), .nmi_busy_i(nmi_busy_i),
        .req_o(req_o), .req_idx_o(req_idx_o),
        .act_valid_o(act_valid_o), .act_idx_o(act_idx_o),
        .pend_o(pend_o), .en_o(en_o), .gie_o(gie_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_pend(input logic [NSRC-1:0] v);
        @(negedge clk); pend_wr_i = 1'b1; pend_wdata_i = v;
        @(negedge clk); pend_wr_i = 1'b0;
    endtask

    task automatic wr_en(input logic [NSRC-1:0] v);
        @(negedge clk); en_wr_i = 1'b1; en_wdata_i = v;
        @(negedge clk); en_wr_i = 1'b0;
    endtask

    task automatic wr_gie(input logic v);
        @(negedge clk); gie_wr_i = 1'b1; gie_wdata_i = v;
        @(negedge clk); gie_wr_i = 1'b0;
    endtask

    // Strobe one instruction start; returns the request seen in the next cycle.
    task automatic strobe(output logic r, output logic [IDXW-1:0] ix);
        @(negedge clk); instr_start_i = 1'b1;
        @(negedge clk); instr_start_i = 1'b0;
        r = req_o; ix = req_idx_o;
    endtask

    function automatic int top_bit(input logic [NSRC-1:0] v);
        int t = 0;
        for (int k = 0; k < NSRC; k++) if (v[k]) t = k;
        return t;
    endfunction

    initial begin : main
        logic r;
        logic [IDXW-1:0] ix;
        repeat (3) @(negedge clk);
        // R5: reset state
        check(pend_o == '0 && en_o == '0 && !gie_o && !req_o && !act_valid_o,
              "R5 reset state", {pend_o, en_o, gie_o, req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: event sets pending with enables and GIE clear
        evt_i[3] = 1'b1;
        repeat (3) @(negedge clk);
        check(pend_o == 15'h0008, "R1 event sets pending", pend_o, 15'h0008);
        // R10: held level does not re-set after clear
        wr_pend('0);
        repeat (5) @(negedge clk);
        check(pend_o == '0, "R10 held level no retrigger", pend_o, 0);
        evt_i[3] = 1'b0;
        repeat (4) @(negedge clk);

        // R8: event edge and clearing write on the same clock edge
        evt_i[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pend_wr_i = 1'b1; pend_wdata_i = '0;
        @(negedge clk);
        pend_wr_i = 1'b0;
        check(pend_o[5] == 1'b1, "R8 event beats clear", pend_o, 15'h0020);
        evt_i[5] = 1'b0;
        wr_pend('0);
        check(pend_o == '0, "R7 write clears pending", pend_o, 0);

        // R3: no request while GIE is clear
        wr_pend(15'h0001); wr_en(15'h0001);
        strobe(r, ix);
        check(!r, "R3 GIE clear blocks", r, 0);
        wr_gie(1'b1);
        // R3: no request during non-maskable service
        nmi_busy_i = 1'b1;
        strobe(r, ix);
        check(!r, "R3 nmi busy blocks", r, 0);
        nmi_busy_i = 1'b0;
        // R3: no request without instruction start
        repeat (3) @(negedge clk);
        check(!req_o, "R3 no strobe no request", req_o, 0);
        strobe(r, ix);
        check(r && ix == 0, "R3 request fires", {r, ix}, 16);
        @(negedge clk);
        check(!req_o, "R3 one-cycle pulse", req_o, 0);
        // R7: request leaves pending set
        check(pend_o == 15'h0001, "R7 pending kept after request", pend_o, 1);

        // R6: pending before enable fires at next strobe
        wr_en('0);
        wr_pend(15'h0400);
        strobe(r, ix);
        check(!r, "R6 disabled source silent", r, 0);
        wr_en(15'h0400);
        strobe(r, ix);
        check(r && ix == 10, "R6 late enable fires", {r, ix}, 16 + 10);

        // R4: every pair of sources, highest index wins, both stay pending
        wr_en('1);
        for (int i = 0; i < NSRC; i++) begin
            for (int j = i; j < NSRC; j++) begin
                logic [NSRC-1:0] m;
                m = '0; m[i] = 1'b1; m[j] = 1'b1;
                wr_pend(m);
                check(act_valid_o && int'(act_idx_o) == top_bit(m), "R2 active index",
                      act_idx_o, top_bit(m));
                strobe(r, ix);
                check(r && int'(ix) == j, "R4 pair winner", {r, ix}, 16 + j);
                check(pend_o == m, "R4 losers stay pending", pend_o, m);
            end
        end

        // R2: enable mask selects, all pending
        wr_pend('1);
        for (int k = 0; k < NSRC; k++) begin
            logic [NSRC-1:0] e;
            e = '0; e[k] = 1'b1;
            wr_en(e);
            check(act_valid_o && int'(act_idx_o) == k, "R2 enable mask", act_idx_o, k);
            strobe(r, ix);
            check(r && int'(ix) == k, "R4 masked winner", {r, ix}, 16 + k);
        end
        wr_en('0);
        check(!act_valid_o && act_idx_o == '0, "R2 nothing active", {act_valid_o, act_idx_o}, 0);

        // R9: global enable control priorities
        wr_gie(1'b0);
        @(negedge clk); gie_set_i = 1'b1;
        @(negedge clk); gie_set_i = 1'b0;
        check(gie_o, "R9 set pulse", gie_o, 1);
        @(negedge clk); gie_set_i = 1'b1; gie_clr_i = 1'b1;
        @(negedge clk); gie_set_i = 1'b0; gie_clr_i = 1'b0;
        check(!gie_o, "R9 clear beats set", gie_o, 0);
        @(negedge clk); gie_wr_i = 1'b1; gie_wdata_i = 1'b1; gie_clr_i = 1'b1;
        @(negedge clk); gie_wr_i = 1'b0; gie_clr_i = 1'b0;
        check(!gie_o, "R9 clear beats write", gie_o, 0);
        @(negedge clk); gie_wr_i = 1'b1; gie_wdata_i = 1'b0; gie_set_i = 1'b1;
        @(negedge clk); gie_wr_i = 1'b0; gie_set_i = 1'b0;
        check(gie_o, "R9 set beats write", gie_o, 1);
        wr_gie(1'b0);
        check(!gie_o, "R9 write zero", gie_o, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule